// File: doc/BRIEF.md
# Serial-Bus Twelve-Channel Converter Latch Front-End

This block is the digital front-end of a multichannel resistor-ladder converter. It listens as a write-only target on a two-wire serial bus (I2C). It accepts frames of four parts: an address byte with the write bit, a channel byte, a data byte, and an end marker. The data byte goes into one of twelve 8-bit holding latches, and each latch drives one analog ladder.

The 7-bit target address has two parts. The upper four bits are fixed. The lower three bits come from three strap pins, so up to eight of these blocks can share one bus. The block sees the bus through its own system clock, which must run at least eight times the bus bit rate. Both bus lines pass through a two-stage synchroniser and are then edge-detected. The block acknowledges each byte it accepts by pulling the data line low through an open-drain enable output.

Top module: `i2c_dac_latch_bank`

## Requirements
- R1: While rst_n is low, and after it is released, every latch reads 0x00 and sda_pull_low is 0.
- R2: An address byte is accepted when its first four bits are 1,0,0,1, the next three bits equal cs_pins[2], cs_pins[1], cs_pins[0] in that order, and its eighth bit is 0. An accepted address byte is acknowledged: SDA is held low during the following (ninth) SCL high phase.
- R3: If the address byte does not match (wrong fixed bits, wrong strap bits, or eighth bit 1), none of that byte or the later bytes are acknowledged and no latch changes until the next start condition.
- R4: After an accepted address, the channel byte and the data byte are each acknowledged in their ninth clock. sda_pull_low changes only while SCL is low.
- R5: The data byte is taken MSB first. The low four bits of the channel byte form a code n. For n in 1 to 12, the code selects ch_value[(n-1)*8 +: 8]. The upper four bits of the channel byte are ignored.
- R6: Only the selected latch changes. It takes the data byte after the data byte's ninth clock ends, and no other latch changes at any time.
- R7: Channel codes 0, 13, 14 and 15 are acknowledged in all three bytes but change no latch.
- R8: A start or stop condition before the data byte's acknowledge completes abandons the frame with no latch write. A start condition always begins a new frame.
- R9: Once a frame has written its latch, further bytes before the next start are not acknowledged and change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND result) |
| cs_pins | input | 3 | Strap pins matched against the low address bits |
| sda_pull_low | output | 1 | Drives the data line low when 1 (acknowledge) |
| ch_value | output | 96 | Twelve 8-bit latches; channel n at bits (n-1)*8 +: 8 |

## Verification
Two actions can coincide. One is the latch write that fires on the SCL fall closing the data byte's acknowledge. The other is the abort caused by a start or stop condition. The bench places stop and repeated-start conditions just after the channel byte's acknowledge and partway through the data byte. The scoreboard has no expected item for these frames, so any latch movement is reported. A later complete frame must then produce exactly its own single write.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 4;
    localparam logic [3:0] ADDR_FIXED = 4'b1001;

    typedef enum logic [2:0] {
        RX_IDLE = 3'd0,
        RX_ADDR = 3'd1,
        RX_SUB  = 3'd2,
        RX_DATA = 3'd3,
        RX_SKIP = 3'd4
    } rx_state_e;

    typedef struct packed {
        rx_state_e              state;
        logic [CNT_W-1:0]       cnt;
        logic [BYTE_W-1:0]      shreg;
        logic [CODE_W-1:0]      chan;
        logic                   ack;
    } rx_regs_t;
endpackage

// File: rtl/dacfe_bus_sync.sv
module dacfe_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_regs_t;

    sync_regs_t q, d;

    assign scl_lvl = q.scl_sh[STAGES-1];
    assign sda_lvl = q.sda_sh[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_in};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_in};
        d.scl_prev = scl_lvl;
        d.sda_prev = sda_lvl;
    end

    assign scl_rise  = scl_lvl && !q.scl_prev;
    assign scl_fall  = !scl_lvl && q.scl_prev;
    assign start_evt = scl_lvl && q.scl_prev && q.sda_prev && !sda_lvl;
    assign stop_evt  = scl_lvl && q.scl_prev && !q.sda_prev && sda_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [2:0]        cs_pins,
    output logic              ack_drive,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_code,
    output logic [BYTE_W-1:0] wr_data,
    output rx_state_e         state_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

    rx_regs_t q, d;
    logic     addr_ok;
    logic     in_byte;

    assign addr_ok = (q.shreg[7:4] == ADDR_FIXED) &&
                     (q.shreg[3:1] == cs_pins) &&
                     !q.shreg[0];
    assign in_byte = (q.state == RX_ADDR) || (q.state == RX_SUB) ||
                     (q.state == RX_DATA);

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_evt) begin
            d.state = RX_ADDR;
            d.cnt   = '0;
            d.ack   = 1'b0;
        end else if (stop_evt) begin
            d.state = RX_IDLE;
            d.cnt   = '0;
            d.ack   = 1'b0;
        end else if (in_byte) begin
            if (scl_rise && (q.cnt < LAST_BIT)) begin
                d.shreg = {q.shreg[BYTE_W-2:0], sda_lvl};
                d.cnt   = q.cnt + 1'b1;
            end else if (scl_fall && (q.cnt == LAST_BIT)) begin
                if ((q.state != RX_ADDR) || addr_ok) begin
                    d.ack = 1'b1;
                    d.cnt = ACK_SLOT;
                end else begin
                    d.state = RX_SKIP;
                    d.cnt   = '0;
                end
            end else if (scl_fall && (q.cnt == ACK_SLOT)) begin
                d.ack = 1'b0;
                d.cnt = '0;
                case (q.state)
                    RX_ADDR: d.state = RX_SUB;
                    RX_SUB: begin
                        d.chan  = q.shreg[CODE_W-1:0];
                        d.state = RX_DATA;
                    end
                    default: begin
                        wr_en   = 1'b1;
                        d.state = RX_SKIP;
                    end
                endcase
            end
        end
    end

    assign ack_drive = q.ack;
    assign wr_code   = q.chan;
    assign wr_data   = q.shreg;
    assign state_o   = q.state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: RX_IDLE, cnt: '0, shreg: '0, chan: '0, ack: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dacfe_latch_bank.sv
module dacfe_latch_bank
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CODE_W-1:0]              wr_code,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_CH-1:0][DATA_W-1:0]  lat_o
);
    logic [NUM_CH-1:0][DATA_W-1:0] lat_q, lat_d;
    logic [NUM_CH-1:0]             hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_code == CODE_W'(g + 1));
    end

    always_comb begin
        lat_d = lat_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) begin
                lat_d[i] = wr_data;
            end
        end
    end

    assign lat_o = lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end
endmodule

// File: rtl/i2c_dac_latch_bank.sv
module i2c_dac_latch_bank
    import dacfe_pkg::*;
#(
    parameter int NUM_CH      = 12,
    parameter int SYNC_STAGES = 2,
    localparam int OUT_W      = NUM_CH * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [2:0]       cs_pins,
    output logic             sda_pull_low,
    output logic [OUT_W-1:0] ch_value
);
    logic                          scl_lvl, sda_lvl;
    logic                          scl_rise, scl_fall;
    logic                          start_evt, stop_evt;
    logic                          wr_en;
    logic [CODE_W-1:0]             wr_code;
    logic [BYTE_W-1:0]             wr_data;
    rx_state_e                     rx_state;
    logic [NUM_CH-1:0][BYTE_W-1:0] lat;

    dacfe_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    dacfe_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .cs_pins   (cs_pins),
        .ack_drive (sda_pull_low),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .wr_data   (wr_data),
        .state_o   (rx_state)
    );

    dacfe_latch_bank #(.NUM_CH(NUM_CH), .DATA_W(BYTE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_data (wr_data),
        .lat_o   (lat)
    );

    assign ch_value = lat;
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_in,
    input logic                       sda_pull_low,
    input logic [NUM_CH*BYTE_W-1:0]   ch_value,
    input logic                       wr_en,
    input logic [CODE_W-1:0]          wr_code,
    input rx_state_e                  rx_state
);
    logic [NUM_CH*BYTE_W-1:0] prev_val;
    logic [NUM_CH-1:0]        chg;
    logic                     bad_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_val <= '0;
        end else begin
            prev_val <= ch_value;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
        assign chg[g] = ch_value[g*BYTE_W +: BYTE_W] != prev_val[g*BYTE_W +: BYTE_W];
    end

    assign bad_code = (wr_code == '0) || (wr_code > CODE_W'(NUM_CH));

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> !scl_in); // R4
    AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_state == RX_SKIP) || (rx_state == RX_IDLE)) |-> !sda_pull_low); // R3
    AST_SINGLE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1); // R6
    AST_WRITE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_value != $past(ch_value)) |-> $past(wr_en)); // R8
    AST_BAD_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_code) |=> $stable(ch_value)); // R7
endmodule

bind i2c_dac_latch_bank dacfe_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_in),
    .sda_pull_low (sda_pull_low),
    .ch_value     (ch_value),
    .wr_en        (wr_en),
    .wr_code      (wr_code),
    .rx_state     (rx_state)
);

// File: tb/sim_i2c_dac_latch_bank.sv
`timescale 1ns/1ps
module sim_i2c_dac_latch_bank;
    localparam int NCH = 12;
    localparam int Q   = 10;

    typedef struct {
        int         ch;
        logic [7:0] val;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl = 1'b1;
    logic            m_sda = 1'b1;
    logic [2:0]      cs = 3'b101;
    logic            sda_pull_low;
    logic [NCH*8-1:0] ch_value;
    logic            sda_bus;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    exp_t sb_q[$];
    logic [7:0] model [NCH];

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull_low;

    i2c_dac_latch_bank u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .cs_pins      (cs),
        .sda_pull_low (sda_pull_low),
        .ch_value     (ch_value)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(Q);
            scl = 1'b1;   wq(2 * Q);
            scl = 1'b0;   wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic got;
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        @(negedge clk);
        got = ~sda_bus;
        check(got == exp_ack, req, 96'(got), 96'(exp_ack));
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic push_exp(input int code, input logic [7:0] v);
        exp_t e;
        e.ch  = code - 1;
        e.val = v;
        sb_q.push_back(e);
        model[code - 1] = v;
    endtask

    task automatic frame(input logic [7:0] addr, input logic [7:0] sub, input logic [7:0] dat,
                         input bit addr_ok, input string req);
        int code;
        code = int'(sub[3:0]);
        bus_start();
        send_byte(addr, addr_ok, req);
        send_byte(sub, addr_ok, req);
        if (addr_ok && code >= 1 && code <= NCH) push_exp(code, dat);
        send_byte(dat, addr_ok, req);
        bus_stop();
        wq(2 * Q);
    endtask

    task automatic check_model(input string req);
        logic [NCH*8-1:0] exp_v;
        for (int i = 0; i < NCH; i++) exp_v[i*8 +: 8] = model[i];
        @(negedge clk);
        check(ch_value == exp_v && sb_q.size() == 0, req, 96'(ch_value), 96'(exp_v));
    endtask

    // monitor: pop an expected item for every latch change seen
    initial begin
        logic [NCH*8-1:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n && ch_value != prev) begin
                for (int i = 0; i < NCH; i++) begin
                    if (ch_value[i*8 +: 8] != prev[i*8 +: 8]) begin
                        if (sb_q.size() == 0) begin
                            check(1'b0, "R6 unexpected latch write", 96'(i * 256 + ch_value[i*8 +: 8]), 96'(0));
                        end else begin
                            exp_t e;
                            e = sb_q.pop_front();
                            check(e.ch == i && e.val == ch_value[i*8 +: 8], "R5 R6 scoreboard",
                                  96'(i * 256 + ch_value[i*8 +: 8]), 96'(e.ch * 256 + e.val));
                        end
                    end
                end
            end
            prev = ch_value;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 96'(0), 96'(1));
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) model[i] = 8'h00;
        wq(3);
        @(negedge clk);
        check(ch_value == '0 && !sda_pull_low, "R1 in reset", 96'(ch_value), 96'(0));
        wq(2);
        rst_n = 1'b1;
        wq(Q);
        @(negedge clk);
        check(ch_value == '0 && !sda_pull_low, "R1 after reset", 96'(ch_value), 96'(0));

        // R2 R4 R5: basic writes, address 1001_101, write bit 0
        frame(8'b1001_1010, 8'h01, 8'hA5, 1'b1, "R2 R4 ack ch1");
        frame(8'b1001_1010, 8'hFC, 8'h3C, 1'b1, "R5 upper nibble ignored ch12");
        frame(8'b1001_1010, 8'h07, 8'h81, 1'b1, "R5 ch7");
        check_model("R5 R6 after basic writes");

        // R7: unused codes acked, no write
        frame(8'b1001_1010, 8'h00, 8'h55, 1'b1, "R7 code 0");
        frame(8'b1001_1010, 8'h0D, 8'h66, 1'b1, "R7 code 13");
        frame(8'b1001_1010, 8'h5F, 8'h77, 1'b1, "R7 code 15");
        check_model("R7 no latch change");

        // R3: mismatching addresses
        frame(8'b1001_0000, 8'h02, 8'h11, 1'b0, "R3 wrong strap bits");
        frame(8'b1011_1010, 8'h02, 8'h22, 1'b0, "R3 wrong fixed bits");
        frame(8'b1001_1011, 8'h02, 8'h33, 1'b0, "R3 read bit");
        check_model("R3 no latch change");

        // R8: stop after channel byte
        bus_start();
        send_byte(8'b1001_1010, 1'b1, "R8 addr");
        send_byte(8'h02, 1'b1, "R8 sub");
        bus_stop();
        wq(2 * Q);
        // R8: repeated start halfway through data byte, then full frame to ch3
        bus_start();
        send_byte(8'b1001_1010, 1'b1, "R8 addr2");
        send_byte(8'h04, 1'b1, "R8 sub2");
        send_bits(8'hF0, 4);
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
        send_byte(8'b1001_1010, 1'b1, "R8 restart addr");
        send_byte(8'h03, 1'b1, "R8 restart sub");
        push_exp(3, 8'h9E);
        send_byte(8'h9E, 1'b1, "R8 restart data");
        // R9: extra byte after completed frame
        send_byte(8'h42, 1'b0, "R9 extra byte nack");
        bus_stop();
        wq(2 * Q);
        check_model("R8 R9 only ch3 written");

        // R2: new strap value
        cs = 3'b000;
        wq(Q);
        frame(8'b1001_1010, 8'h05, 8'hEE, 1'b0, "R2 old strap rejected");
        frame(8'b1001_0000, 8'h0C, 8'h5A, 1'b1, "R2 strap 000 ch12");
        frame(8'b1001_0000, 8'h0B, 8'h01, 1'b1, "R5 ch11");
        check_model("R2 R6 final model");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule